// File: doc/BRIEF.md
# SPI Serial Clock and Sample-Timing Unit

This block produces the serial clock for an SPI flash port by dividing the faster system clock. It moves one byte per chip-select frame, most significant bit first, in SPI mode 0. A `start` pulse while idle loads a transmit byte and latches the timing controls. The block then lowers chip-select, waits a lead interval, runs eight serial clock periods, holds a short tail and releases chip-select.

All launch and capture points fall on system-clock boundaries. The divider code selects a half period H of 1, 2, 3, 4, 8, 12 or 16 system clocks. The transmit-advance bit moves every data change on `mosi` one system clock earlier, to cover the output pad delay. The receive-delay field moves the capture of `miso` from the falling-edge point by a whole number of system clocks, to cover the round trip through the pads and the flash. The delay is clamped so that capture never reaches the next rising edge. A one-cycle strobe presents each received byte.

Top module: `spi_clk_timing`

## Requirements
- R1: `div_sel` codes 0..6 divide the system clock by 2, 4, 6, 8, 16, 24 and 32. Codes 7 and above divide by 32. The half period H is the ratio divided by 2.
- R2: `sclk` is low whenever no frame is active. Within a frame it gives 8 periods, each made of H cycles low followed by H cycles high (mode 0).
- R3: `cs_n` goes low in the cycle after `start` is sampled while idle. It stays low for 2H cycles before the first low half of `sclk`, and for H cycles after the last falling edge. It then returns high.
- R4: With `tx_adv`=0, `mosi` carries bit 7 down to bit 0 of the loaded byte. Each bit is held for the whole 2H-cycle period that begins with its low half. Outside those periods `mosi` is 0.
- R5: With `tx_adv`=1, every `mosi` value appears exactly one system clock earlier than in R4.
- R6: With `rx_dly`=0, each `miso` bit is sampled at the system-clock edge where `sclk` falls.
- R7: `rx_dly`=d delays each sample by min(d, H-1) system clocks after the falling edge. With divide-by-2 the delay is therefore always 0.
- R8: `rx_valid` is high for exactly one cycle, the cycle after the eighth sample. In that cycle `rx_byte` holds the sampled bits, the first sample in bit 7.
- R9: A `start` pulse during an active frame is ignored. Changes to `div_sel`, `tx_adv`, `rx_dly` or `tx_byte` during a frame do not affect it.
- R10: During reset `cs_n` is 1 and `sclk`, `mosi` and `rx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 3 | Divide ratio code |
| tx_adv | input | 1 | Launch transmit data one cycle early |
| rx_dly | input | 3 | Capture delay in system clocks |
| start | input | 1 | Begin a one-byte frame when idle |
| tx_byte | input | 8 | Byte to transmit |
| miso | input | 1 | Serial data from the flash |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip-select, active low |
| mosi | output | 1 | Serial data to the flash |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |

## Verification
The bound checker covers the properties that hold in every cycle. It checks that the clock and data outputs stay quiet while chip-select is high and that chip-select rises only with the clock low. It also checks that the byte strobe lasts a single cycle and only comes inside a frame. The exact cycle of every `sclk`, `mosi` and `cs_n` change, and the cycle in which `miso` is sampled, depend on the divider, the advance bit and the clamped delay together, so only the bench scenarios can show them. For those the bench drives `miso` so that the correct bit is present only in the intended sample cycle, with the opposite value in the cycles on either side.

// File: rtl/spi_clk_timing.sv
module spi_clk_timing #(
  parameter int BITS = 8,
  parameter int HCW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      div_sel,
  input  logic            tx_adv,
  input  logic [2:0]      rx_dly,
  input  logic            start,
  input  logic [BITS-1:0] tx_byte,
  input  logic            miso,
  output logic            sclk,
  output logic            cs_n,
  output logic            mosi,
  output logic [BITS-1:0] rx_byte,
  output logic            rx_valid
);
  localparam int HIW = $clog2(2*BITS);
  localparam int BW  = $clog2(BITS);
  localparam logic [HIW-1:0] HI_LAST = HIW'(2*BITS-1);

  typedef enum logic [1:0] {IDLE, LEAD, SHIFT, TAIL} st_t;

  function automatic logic [HCW-1:0] half_m1(input logic [2:0] c);
    case (c)
      3'd0: return HCW'(0);
      3'd1: return HCW'(1);
      3'd2: return HCW'(2);
      3'd3: return HCW'(3);
      3'd4: return HCW'(7);
      3'd5: return HCW'(11);
      default: return HCW'(15);
    endcase
  endfunction

  st_t             st;
  logic [HCW-1:0]  hc, hm1;
  logic [HIW-1:0]  hi;
  logic            adv_q, pend;
  logic [2:0]      dly_q, dcnt;
  logic [BITS-1:0] txq, rxsh;
  logic [BW-1:0]   rxn;

  logic [HCW-1:0]  hm1_new;
  logic [2:0]      dly_new;
  logic            last_half, fall_ev, cap;
  logic            nxt_shift;
  logic [BW-1:0]   cur_idx, nxt_idx;
  logic            mosi_now, mosi_adv;

  assign hm1_new   = half_m1(div_sel);
  assign dly_new   = (HCW'(rx_dly) > hm1_new) ? hm1_new[2:0] : rx_dly;
  assign last_half = (hc == hm1);
  assign fall_ev   = (st == SHIFT) && hi[0] && last_half;
  assign cap       = (fall_ev && dly_q == 3'd0) || (pend && dcnt == 3'd1);

  assign cs_n    = (st == IDLE);
  assign sclk    = (st == SHIFT) && hi[0];
  assign cur_idx = hi[HIW-1:1];

  always_comb begin
    nxt_shift = 1'b0;
    nxt_idx   = cur_idx;
    if (st == LEAD && hi[0] && last_half) begin
      nxt_shift = 1'b1;
      nxt_idx   = '0;
    end else if (st == SHIFT) begin
      nxt_shift = 1'b1;
      if (last_half && hi[0]) begin
        if (hi == HI_LAST) nxt_shift = 1'b0;
        else nxt_idx = cur_idx + 1'b1;
      end
    end
  end

  assign mosi_now = (st == SHIFT) ? txq[BW'(BITS-1) - cur_idx] : 1'b0;
  assign mosi_adv = nxt_shift ? txq[BW'(BITS-1) - nxt_idx] : 1'b0;
  assign mosi     = adv_q ? mosi_adv : mosi_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      hc    <= '0;
      hi    <= '0;
      hm1   <= '0;
      adv_q <= 1'b0;
      dly_q <= '0;
      txq   <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          st    <= LEAD;
          hc    <= '0;
          hi    <= '0;
          hm1   <= hm1_new;
          adv_q <= tx_adv;
          dly_q <= dly_new;
          txq   <= tx_byte;
        end
        LEAD: if (last_half) begin
          hc <= '0;
          if (hi[0]) begin
            st <= SHIFT;
            hi <= '0;
          end else hi <= hi + 1'b1;
        end else hc <= hc + 1'b1;
        SHIFT: if (last_half) begin
          hc <= '0;
          if (hi == HI_LAST) st <= TAIL;
          else hi <= hi + 1'b1;
        end else hc <= hc + 1'b1;
        default: if (last_half) st <= IDLE;
                 else hc <= hc + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      dcnt     <= '0;
      rxsh     <= '0;
      rxn      <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (fall_ev && dly_q != 3'd0) begin
        pend <= 1'b1;
        dcnt <= dly_q;
      end else if (pend) begin
        dcnt <= dcnt - 1'b1;
        if (dcnt == 3'd1) pend <= 1'b0;
      end
      if (st == IDLE && start) begin
        rxn <= '0;
      end else if (cap) begin
        rxsh <= {rxsh[BITS-2:0], miso};
        rxn  <= rxn + 1'b1;
        if (rxn == BW'(BITS-1)) begin
          rx_byte  <= {rxsh[BITS-2:0], miso};
          rx_valid <= 1'b1;
        end
      end
    end
  end
endmodule

module spi_clk_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic sclk,
  input logic cs_n,
  input logic mosi,
  input logic rx_valid
);
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  p_mosi_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !mosi);
  p_cs_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !sclk && !$past(sclk));
  p_cs_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && start) |=> !cs_n);
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_valid_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !cs_n);
  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |-> cs_n && !sclk && !mosi && !rx_valid);
endmodule

bind spi_clk_timing spi_clk_timing_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .sclk(sclk),
  .cs_n(cs_n), .mosi(mosi), .rx_valid(rx_valid)
);

// File: tb/spi_clk_timing_tb.sv
module spi_clk_timing_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] div_sel = '0;
  logic tx_adv = 1'b0;
  logic [2:0] rx_dly = '0;
  logic start = 1'b0;
  logic [7:0] tx_byte = '0;
  logic miso = 1'b0;
  logic sclk, cs_n, mosi, rx_valid;
  logic [7:0] rx_byte;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_clk_timing dut_i (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .tx_adv(tx_adv),
    .rx_dly(rx_dly), .start(start), .tx_byte(tx_byte), .miso(miso),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .rx_byte(rx_byte),
    .rx_valid(rx_valid)
  );

  function automatic int half_of(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 4;
      4: return 8;
      5: return 12;
      default: return 16;
    endcase
  endfunction

  function automatic logic exp_mosi(input int n, input int h, input logic [7:0] b);
    int p = n - 2*h - 1;
    if (p < 0 || p >= 16*h) return 1'b0;
    return b[7 - p/(2*h)];
  endfunction

  function automatic logic miso_at(input int n, input int h, input int d, input logic [7:0] b);
    for (int k = 0; k < 8; k++) if (n == (2*k+4)*h + d) return b[7-k];
    for (int k = 0; k < 8; k++)
      if (n == (2*k+4)*h + d - 1 || n == (2*k+4)*h + d + 1) return ~b[7-k];
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_reset();
    @(negedge clk);
    check(cs_n == 1'b1, "R10", "cs_n in reset", cs_n, 1);
    check({sclk, mosi, rx_valid} == 3'b000, "R10", "sclk/mosi/rx_valid in reset",
          {sclk, mosi, rx_valid}, 0);
  endtask

  task automatic run_frame(input int code, input bit adv, input int dly,
                           input logic [7:0] tb, input logic [7:0] rb,
                           input bit disturb, input string tag);
    int h = half_of(code);
    int d = (dly < h-1) ? dly : h-1;
    int last = 19*h + 1;
    int vcyc = 18*h + d + 1;
    int e_n[5], e_a[5], e_x[5];
    bit bad[5];
    for (int i = 0; i < 5; i++) bad[i] = 0;
    @(negedge clk);
    div_sel = 3'(code); tx_adv = adv; rx_dly = 3'(dly); tx_byte = tb; start = 1'b1;
    miso = 1'b0;
    for (int n = 1; n <= last; n++) begin
      @(negedge clk);
      start = 1'b0;
      if (disturb && n == 5) begin
        start = 1'b1; tx_byte = ~tb; div_sel = 3'(code ^ 1); tx_adv = ~adv; rx_dly = 3'd7;
      end
      begin
        int p = n - 2*h - 1;
        logic es = (p >= 0 && p < 16*h) && ((p/h) % 2 == 1);
        logic ec = !(n >= 1 && n <= 19*h);
        logic em = adv ? exp_mosi(n+1, h, tb) : exp_mosi(n, h, tb);
        logic ev = (n == vcyc);
        if (sclk !== es && !bad[0]) begin bad[0] = 1; e_n[0] = n; e_a[0] = int'(sclk); e_x[0] = int'(es); end
        if (cs_n !== ec && !bad[1]) begin bad[1] = 1; e_n[1] = n; e_a[1] = int'(cs_n); e_x[1] = int'(ec); end
        if (mosi !== em && !bad[2]) begin bad[2] = 1; e_n[2] = n; e_a[2] = int'(mosi); e_x[2] = int'(em); end
        if (rx_valid !== ev && !bad[3]) begin bad[3] = 1; e_n[3] = n; e_a[3] = int'(rx_valid); e_x[3] = int'(ev); end
        if (ev && rx_byte !== rb && !bad[4]) begin bad[4] = 1; e_n[4] = n; e_a[4] = int'(rx_byte); e_x[4] = int'(rb); end
      end
      miso = miso_at(n, h, d, rb);
    end
    check(!bad[0], {tag, " R1 R2"}, $sformatf("sclk at cycle %0d", e_n[0]), e_a[0], e_x[0]);
    check(!bad[1], {tag, " R3"}, $sformatf("cs_n at cycle %0d", e_n[1]), e_a[1], e_x[1]);
    check(!bad[2], {tag, adv ? " R5" : " R4"}, $sformatf("mosi at cycle %0d", e_n[2]), e_a[2], e_x[2]);
    check(!bad[3], {tag, " R6 R7 R8"}, $sformatf("rx_valid at cycle %0d", e_n[3]), e_a[3], e_x[3]);
    check(!bad[4], {tag, " R6 R7 R8"}, $sformatf("rx_byte at cycle %0d", e_n[4]), e_a[4], e_x[4]);
    @(negedge clk);
    div_sel = '0; tx_adv = 1'b0; rx_dly = '0; start = 1'b0;
  endtask

  task automatic t_div2();
    run_frame(0, 0, 0, 8'hA5, 8'h3C, 0, "div2 R1 R6");
    run_frame(0, 0, 5, 8'h5A, 8'hC3, 0, "div2 clamp R7");
  endtask

  task automatic t_mid_ratios();
    run_frame(1, 1, 1, 8'h81, 8'h7E, 0, "div4 adv R5 R7");
    run_frame(2, 0, 3, 8'hC6, 8'h95, 0, "div6 clamp R7");
    run_frame(3, 1, 0, 8'h3B, 8'hE4, 0, "div8 adv R5 R6");
  endtask

  task automatic t_slow_ratios();
    run_frame(4, 0, 7, 8'hF0, 8'h0F, 0, "div16 R7");
    run_frame(5, 1, 7, 8'h69, 8'hB2, 0, "div24 R7");
    run_frame(6, 0, 2, 8'h12, 8'hED, 0, "div32 R7");
    run_frame(7, 0, 4, 8'hD7, 8'h48, 0, "code7 R1");
  endtask

  task automatic t_ignore_mid_frame();
    run_frame(2, 0, 1, 8'hB4, 8'h2D, 1, "busy start R9");
  endtask

  initial begin
    check_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_div2();
    t_mid_ratios();
    t_slow_ratios();
    t_ignore_mid_frame();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule